// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the execute stage for a 64-bit integer shift and rotate instruction class. It takes one 32-bit instruction word and two register values, decodes the word, and computes the result. The operand read from the first source field is `rj_val` and the one from the second is `rk_val`. It recognises sixteen operations built from four kinds: logical left, logical right, arithmetic right and rotate right. Each kind comes in a 32-bit word width and a 64-bit doubleword width. The shift amount comes either from a register or from an immediate field.

Word operations work on the low half of `rj_val` only and always give a result sign-extended to 64 bits. Doubleword operations use the whole operand. Decoding and shifting are combinational. The result, destination index, write enable and illegal flag are captured in registers on a rising clock edge when `in_valid` is high. Register file access and pipeline control belong to the surrounding core.

Top module: `shift_rotate_unit`

## Requirements
- R1: The destination index output takes instr[4:0] of the accepted instruction. A register-form shift count comes from `rk_val`. A word immediate count is instr[14:10] and a doubleword immediate count is instr[15:10].
- R2: The register forms are decoded from instr[31:15]. Left word is 0x2E, right logical word is 0x2F and right arithmetic word is 0x30. Left doubleword is 0x31, right logical doubleword is 0x32 and right arithmetic doubleword is 0x33. Rotate word is 0x36 and rotate doubleword is 0x37.
- R3: The word immediate forms are decoded from instr[31:15]. Left is 0x81, right logical is 0x89, right arithmetic is 0x91 and rotate is 0x99.
- R4: The doubleword immediate forms are decoded from instr[31:16]. Left is 0x41, right logical is 0x45, right arithmetic is 0x49 and rotate is 0x4D.
- R5: A register-form word operation uses only `rk_val[4:0]` as its count. A register-form doubleword operation uses only `rk_val[5:0]`. Higher bits have no effect.
- R6: A word right shift zero-extends the low 32 bits of `rj_val` for the logical form and sign-extends them for the arithmetic form.
- R7: Every word result, including left shift and rotate, is its 32-bit value sign-extended to 64 bits.
- R8: A word rotate turns only `rj_val[31:0]`, and bits leaving bit 0 enter at bit 31. A doubleword rotate turns all 64 bits.
- R9: Doubleword operations use all 64 bits of `rj_val` with no extension and return the full 64-bit result.
- R10: An accepted word that matches none of the sixteen encodings sets `illegal` and clears `wr_en`. A legal one clears `illegal`.
- R11: `wr_en` stays low when the destination index is 0.
- R12: In a cycle with `in_valid` low, the next `wr_en` and `illegal` are 0, and `result` and `dst_idx` keep their values.
- R13: A synchronous active-high `rst` clears `result`, `dst_idx`, `wr_en` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rj_val | input | 64 | Value to be shifted |
| rk_val | input | 64 | Register shift count source |
| result | output | 64 | Registered result |
| dst_idx | output | 5 | Registered destination register index |
| wr_en | output | 1 | Registered write enable for the destination |
| illegal | output | 1 | Registered unrecognised-encoding flag |

## Verification
The assertions check the following on every cycle:
- `illegal` and `wr_en` are never high together.
- No write targets index 0.
- Idle cycles clear the flags and hold the result.
- Accepted word-class encodings produce a sign-extended result.
- Reset clears all outputs.

Only the bench scenarios can show that the result values are correct. The bench sweeps all sixteen opcodes over every shift count with several operand patterns. It sets high bits in `rk_val` to confirm count masking. It also covers neighbouring unused opcodes and the rotate wrap at counts 0, 31 and 63.

// File: rtl/shift_pkg.sv
package shift_pkg;

    localparam int XLEN     = 64;
    localparam int HALF     = XLEN / 2;
    localparam int AMT_W    = $clog2(XLEN);
    localparam int REG_IDXW = 5;

    typedef enum logic [1:0] {
        KIND_SLL = 2'd0,
        KIND_SRL = 2'd1,
        KIND_SRA = 2'd2,
        KIND_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic                legal;
        logic                is_word;
        shift_kind_e         kind;
        logic [AMT_W-1:0]    amt;
        logic [REG_IDXW-1:0] rd;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0]     result;
        logic [REG_IDXW-1:0] dst;
        logic                wr_en;
        logic                illegal;
    } out_t;

endpackage

// File: rtl/shift_barrel.sv
module shift_barrel #(
    parameter int W  = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          rotate,
    input  logic          fill,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [0:SW];

    assign stage[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [SH-1:0] upper_d;

        always_comb begin
            upper_d = rotate ? stage[s][SH-1:0] : {SH{fill}};
            if (amt[s]) begin
                stage[s+1] = {upper_d, stage[s][W-1:SH]};
            end else begin
                stage[s+1] = stage[s];
            end
        end
    end

    assign dout = stage[SW];

endmodule

// File: rtl/shift_decoder.sv
module shift_decoder
    import shift_pkg::*;
#(
    parameter int OPW = 32
) (
    input  logic [OPW-1:0]  instr,
    input  logic [XLEN-1:0] rk_val,
    output dec_t            dec
);

    logic [16:0] op17;
    logic [15:0] op16;
    logic [AMT_W-1:0] reg_word_amt;
    logic [AMT_W-1:0] reg_dbl_amt;
    logic [AMT_W-1:0] imm_word_amt;
    logic [AMT_W-1:0] imm_dbl_amt;
    logic unused_dec_bits;

    assign op17 = instr[31:15];
    assign op16 = instr[31:16];

    assign reg_word_amt = {1'b0, rk_val[4:0]};
    assign reg_dbl_amt  = rk_val[5:0];
    assign imm_word_amt = {1'b0, instr[14:10]};
    assign imm_dbl_amt  = instr[15:10];

    assign unused_dec_bits = ^{instr[9:5], rk_val[XLEN-1:AMT_W]};

    always_comb begin
        dec         = '0;
        dec.rd      = instr[4:0];
        dec.kind    = KIND_SLL;

        case (op17)
            17'h0002E: begin dec.legal = 1'b1; dec.is_word = 1'b1; dec.kind = KIND_SLL; dec.amt = reg_word_amt; end
            17'h0002F: begin dec.legal = 1'b1; dec.is_word = 1'b1; dec.kind = KIND_SRL; dec.amt = reg_word_amt; end
            17'h00030: begin dec.legal = 1'b1; dec.is_word = 1'b1; dec.kind = KIND_SRA; dec.amt = reg_word_amt; end
            17'h00036: begin dec.legal = 1'b1; dec.is_word = 1'b1; dec.kind = KIND_ROR; dec.amt = reg_word_amt; end
            17'h00031: begin dec.legal = 1'b1; dec.kind = KIND_SLL; dec.amt = reg_dbl_amt; end
            17'h00032: begin dec.legal = 1'b1; dec.kind = KIND_SRL; dec.amt = reg_dbl_amt; end
            17'h00033: begin dec.legal = 1'b1; dec.kind = KIND_SRA; dec.amt = reg_dbl_amt; end
            17'h00037: begin dec.legal = 1'b1; dec.kind = KIND_ROR; dec.amt = reg_dbl_amt; end
            17'h00081: begin dec.legal = 1'b1; dec.is_word = 1'b1; dec.kind = KIND_SLL; dec.amt = imm_word_amt; end
            17'h00089: begin dec.legal = 1'b1; dec.is_word = 1'b1; dec.kind = KIND_SRL; dec.amt = imm_word_amt; end
            17'h00091: begin dec.legal = 1'b1; dec.is_word = 1'b1; dec.kind = KIND_SRA; dec.amt = imm_word_amt; end
            17'h00099: begin dec.legal = 1'b1; dec.is_word = 1'b1; dec.kind = KIND_ROR; dec.amt = imm_word_amt; end
            default: begin
                case (op16)
                    16'h0041: begin dec.legal = 1'b1; dec.kind = KIND_SLL; dec.amt = imm_dbl_amt; end
                    16'h0045: begin dec.legal = 1'b1; dec.kind = KIND_SRL; dec.amt = imm_dbl_amt; end
                    16'h0049: begin dec.legal = 1'b1; dec.kind = KIND_SRA; dec.amt = imm_dbl_amt; end
                    16'h004D: begin dec.legal = 1'b1; dec.kind = KIND_ROR; dec.amt = imm_dbl_amt; end
                    default:  dec.legal = 1'b0;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
    import shift_pkg::*;
(
    input  dec_t            dec,
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] res
);

    logic [HALF-1:0]  lo;
    logic [XLEN-1:0]  prep;
    logic [XLEN-1:0]  prep_rev;
    logic [XLEN-1:0]  to_shift;
    logic [XLEN-1:0]  shifted;
    logic [XLEN-1:0]  shifted_rev;
    logic [XLEN-1:0]  oriented;
    logic [AMT_W-1:0] eff_amt;
    logic             is_left;
    logic             is_rot;
    logic             fill_bit;

    assign lo = src[HALF-1:0];

    // Word rotate duplicates the low half so a 64-bit rotate yields the 32-bit one.
    always_comb begin
        if (dec.is_word) begin
            case (dec.kind)
                KIND_ROR: prep = {lo, lo};
                KIND_SRA: prep = {{HALF{lo[HALF-1]}}, lo};
                default:  prep = {{HALF{1'b0}}, lo};
            endcase
            eff_amt = {1'b0, dec.amt[AMT_W-2:0]};
        end else begin
            prep    = src;
            eff_amt = dec.amt;
        end
    end

    assign is_left  = (dec.kind == KIND_SLL);
    assign is_rot   = (dec.kind == KIND_ROR);
    assign fill_bit = (dec.kind == KIND_SRA) & prep[XLEN-1];

    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign prep_rev[i]    = prep[XLEN-1-i];
        assign shifted_rev[i] = shifted[XLEN-1-i];
    end

    assign to_shift = is_left ? prep_rev : prep;

    shift_barrel #(.W(XLEN)) u_barrel (
        .din    (to_shift),
        .amt    (eff_amt),
        .rotate (is_rot),
        .fill   (fill_bit),
        .dout   (shifted)
    );

    assign oriented = is_left ? shifted_rev : shifted;

    assign res = dec.is_word ? {{HALF{oriented[HALF-1]}}, oriented[HALF-1:0]}
                             : oriented;

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import shift_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [31:0]         instr,
    input  logic [XLEN-1:0]     rj_val,
    input  logic [XLEN-1:0]     rk_val,
    output logic [XLEN-1:0]     result,
    output logic [REG_IDXW-1:0] dst_idx,
    output logic                wr_en,
    output logic                illegal
);

    dec_t            dec;
    logic [XLEN-1:0] comb_res;
    out_t            out_d;
    out_t            out_q;

    shift_decoder #(.OPW(32)) u_dec (
        .instr  (instr),
        .rk_val (rk_val),
        .dec    (dec)
    );

    shift_datapath u_dp (
        .dec (dec),
        .src (rj_val),
        .res (comb_res)
    );

    always_comb begin
        out_d         = out_q;
        out_d.wr_en   = 1'b0;
        out_d.illegal = 1'b0;
        if (in_valid) begin
            out_d.result  = comb_res;
            out_d.dst     = dec.rd;
            out_d.wr_en   = dec.legal && (dec.rd != '0);
            out_d.illegal = !dec.legal;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result  = out_q.result;
    assign dst_idx = out_q.dst;
    assign wr_en   = out_q.wr_en;
    assign illegal = out_q.illegal;

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [63:0] result,
    input logic [4:0]  dst_idx,
    input logic        wr_en,
    input logic        illegal
);

    logic word_class;
    logic unused_chk_bits;

    assign unused_chk_bits = ^instr[14:0];

    always_comb begin
        case (instr[31:15])
            17'h0002E, 17'h0002F, 17'h00030, 17'h00036,
            17'h00081, 17'h00089, 17'h00091, 17'h00099: word_class = 1'b1;
            default:                                    word_class = 1'b0;
        endcase
    end

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wr_en);

    // R11
    no_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (dst_idx != 5'd0));

    // R12
    idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wr_en && !illegal));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(dst_idx)));

    // R7
    word_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && word_class) |=> (result[63:32] == {32{result[31]}}));

    // R13
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result == 64'd0 && dst_idx == 5'd0 && !wr_en && !illegal));

endmodule

bind shift_rotate_unit shift_rotate_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .instr    (instr),
    .result   (result),
    .dst_idx  (dst_idx),
    .wr_en    (wr_en),
    .illegal  (illegal)
);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rj_val = '0;
    logic [63:0] rk_val = '0;
    logic [63:0] result;
    logic [4:0]  dst_idx;
    logic        wr_en;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    shift_rotate_unit u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .instr    (instr),
        .rj_val   (rj_val),
        .rk_val   (rk_val),
        .result   (result),
        .dst_idx  (dst_idx),
        .wr_en    (wr_en),
        .illegal  (illegal)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // op index: 0..3 word register, 4..7 doubleword register, 8..11 word immediate,
    // 12..15 doubleword immediate; kind = index % 4 (left, right logical, right arith, rotate)
    function automatic logic [31:0] encode(int idx, logic [4:0] rd, logic [4:0] rj, logic [5:0] fld);
        logic [16:0] o17;
        logic [15:0] o16;
        case (idx)
            0: o17 = 17'h2E;  1: o17 = 17'h2F;  2: o17 = 17'h30;  3: o17 = 17'h36;
            4: o17 = 17'h31;  5: o17 = 17'h32;  6: o17 = 17'h33;  7: o17 = 17'h37;
            8: o17 = 17'h81;  9: o17 = 17'h89; 10: o17 = 17'h91; 11: o17 = 17'h99;
            default: o17 = '0;
        endcase
        case (idx)
            12: o16 = 16'h41; 13: o16 = 16'h45; 14: o16 = 16'h49; default: o16 = 16'h4D;
        endcase
        if (idx < 12) return {o17, fld[4:0], rj, rd};
        return {o16, fld, rj, rd};
    endfunction

    function automatic logic [63:0] model(int kind, bit word, logic [63:0] a, int n);
        logic [31:0] x;
        logic [31:0] r32;
        if (word) begin
            x = a[31:0];
            case (kind)
                0: r32 = x << n;
                1: r32 = x >> n;
                2: r32 = $signed(x) >>> n;
                default: r32 = (n == 0) ? x : ((x >> n) | (x << (32 - n)));
            endcase
            return {{32{r32[31]}}, r32};
        end
        case (kind)
            0: return a << n;
            1: return a >> n;
            2: return $signed(a) >>> n;
            default: return (n == 0) ? a : ((a >> n) | (a << (64 - n)));
        endcase
    endfunction

    task automatic step(input logic v, input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b);
        in_valid = v;
        instr    = ins;
        rj_val   = a;
        rk_val   = b;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [63:0] pattern(int k);
        case (k)
            0: return 64'h8123_4567_89AB_CDEF;
            1: return 64'h7F00_FF00_F0F0_0F0F;
            2: return 64'h0000_0001_8000_0001;
            default: return 64'hFFFF_FFFF_7FFF_FFFE;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R13 reset state
        check("R13 result", result, 64'd0);
        check("R13 dst", {59'd0, dst_idx}, 64'd0);
        check("R13 flags", {62'd0, wr_en, illegal}, 64'd0);
        rst = 1'b0;

        for (int idx = 0; idx < 16; idx++) begin
            for (int k = 0; k < 4; k++) begin
                for (int n = 0; n < 64; n++) begin
                    int  kind;
                    bit  word;
                    bit  regf;
                    int  lim;
                    logic [4:0] rd;
                    logic [63:0] bval;
                    string tag;
                    kind = idx % 4;
                    word = (idx < 4) || (idx >= 8 && idx < 12);
                    regf = idx < 8;
                    lim  = word ? 32 : 64;
                    if (n < lim) begin
                        rd = 5'((n + k) % 31 + 1);
                        // high count bits set to show they are masked (R5)
                        bval = regf ? ({58'h2AA_AAAA_AAAA_AAAA, 6'(n)} | (word ? 64'hE0 : 64'hC0)) : 64'hFFFF_FFFF_FFFF_FFC0;
                        step(1'b1, encode(idx, rd, 5'(k + 3), regf ? 6'd0 : 6'(n)) | (regf ? {17'd0, 5'(n), 10'd0} : 32'd0),
                             pattern(k), bval);
                        if (idx < 8)       tag = "R2 R5";
                        else if (idx < 12) tag = "R3";
                        else               tag = "R4";
                        if (!word)          tag = {tag, " R9"};
                        else if (kind == 3) tag = {tag, " R8 R7"};
                        else if (kind == 0) tag = {tag, " R7"};
                        else                tag = {tag, " R6 R7"};
                        if (word && kind == 3 || !word && kind == 3) tag = {tag, " R8"};
                        check(tag, result, model(kind, word, pattern(k), n));
                        check("R1 dst", {59'd0, dst_idx}, {59'd0, rd});
                        check("R10 R11 flags", {62'd0, wr_en, illegal}, 64'd2);
                    end
                end
            end
        end

        // R11 destination zero suppresses the write
        step(1'b1, encode(4, 5'd0, 5'd1, 6'd0), pattern(0), 64'd4);
        check("R11 wr_en", {63'd0, wr_en}, 64'd0);
        check("R11 result", result, pattern(0) << 4);
        step(1'b1, encode(13, 5'd0, 5'd1, 6'd63), pattern(3), 64'd0);
        check("R11 wr_en imm", {62'd0, wr_en, illegal}, 64'd0);

        // R10 unused encodings near the legal ones
        for (int j = 0; j < 6; j++) begin
            logic [31:0] bad;
            case (j)
                0: bad = 32'h0000_0000;
                1: bad = 32'hFFFF_FFFF;
                2: bad = {17'h34, 15'h0421};
                3: bad = {17'h2D, 15'h0421};
                4: bad = {16'h43, 16'h0421};
                default: bad = {17'h98, 15'h0421};
            endcase
            step(1'b1, bad, pattern(1), 64'd3);
            check("R10 illegal", {62'd0, wr_en, illegal}, 64'd1);
        end

        // R12 idle cycles hold result and destination, clear flags
        step(1'b1, encode(6, 5'd9, 5'd2, 6'd0), pattern(0), 64'd8);
        held = result;
        check("R12 setup", held, 64'hFF81_2345_6789_ABCD);
        step(1'b0, encode(0, 5'd17, 5'd2, 6'd0), pattern(2), 64'd1);
        check("R12 result hold", result, held);
        check("R12 dst hold", {59'd0, dst_idx}, 64'd9);
        check("R12 flags", {62'd0, wr_en, illegal}, 64'd0);
        step(1'b0, 32'hFFFF_FFFF, pattern(3), 64'd1);
        check("R12 no illegal when idle", {62'd0, wr_en, illegal}, 64'd0);

        // R13 reset after activity
        step(1'b1, encode(7, 5'd5, 5'd2, 6'd0), pattern(0), 64'd1);
        rst = 1'b1;
        step(1'b1, encode(7, 5'd5, 5'd2, 6'd0), pattern(0), 64'd1);
        check("R13 result after run", result, 64'd0);
        check("R13 flags after run", {57'd0, dst_idx, wr_en, illegal}, 64'd0);
        rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule